// File: doc/BRIEF.md
# Way-Predicted Two-Way Cache Lookup

This block is the lookup path of a two-way set-associative cache. Each set stores one prediction bit that names the way to try first. When a request is accepted, the block compares the predicted way's tag. At the same moment, the output data multiplexer is already steered by that bit, so the predicted way's word is on the path before the compare result is known. When the guess is right, the response is ready one cycle after the request is accepted.

When the predicted way's tag does not match, the block spends one more cycle comparing the other way of the same set. It then reports either a hit that came one cycle late or a miss. While this second check runs, the block accepts no new request. After every hit, the set's prediction bit points at the way that hit. A simple fill port writes a tag and data word into a chosen way and also points the prediction bit at that way.

The request address is a word address. Its low `SET_W` bits select the set and the remaining upper bits form the tag. Every response carries a hit flag and a first-try flag, which a prediction-accuracy counter outside the block can count.

Top module: `wp_cache_lookup`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, every line is invalid so that the first lookup misses, and every prediction bit selects way 0.
- R2: A request accepted in cycle N whose predicted way holds a valid line with the matching tag gives `resp_valid`=1 in cycle N+1, with `resp_hit`=1, `resp_first`=1 and `resp_data` equal to that way's word.
- R3: A request whose predicted way does not match, but whose other way holds a valid matching line, gives `resp_valid`=1 in cycle N+2, with `resp_hit`=1, `resp_first`=0 and the other way's word.
- R4: A request that matches in neither way gives `resp_valid`=1 in cycle N+2, with `resp_hit`=0, `resp_first`=0 and `resp_data`=0. The set's prediction bit stays unchanged.
- R5: In cycle N+1 after a mispredicted acceptance, `req_ready` is 0. A request presented in that cycle is ignored: it produces no response and does not change the predictor.
- R6: On every hit, the set's prediction bit is set to the way that hit. The next hit to that same way is therefore a first-try hit.
- R7: A fill with `fill_valid`=1 writes the tag (`fill_addr` upper bits), the data and the valid bit into way `fill_way` of set `fill_addr[SET_W-1:0]`. It replaces any earlier line in that way and points the set's prediction bit at `fill_way`.
- R8: A lookup in the same cycle as a fill sees the contents from before that fill. When a hit and a fill update the same set's prediction bit in one cycle, the fill's way is kept.
- R9: Each set keeps its own prediction bit. Hits and fills in one set do not change the prediction of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Word address: tag in the upper bits, set index in the low SET_W bits |
| req_ready | output | 1 | A request is accepted in this cycle if it is valid |
| fill_valid | input | 1 | Write a line in this cycle |
| fill_addr | input | ADDR_W | Address of the line being written |
| fill_way | input | 1 | Way that receives the line |
| fill_data | input | DATA_W | Word to store |
| resp_valid | output | 1 | One-cycle pulse: a lookup result is present |
| resp_data | output | DATA_W | Word that hit, or 0 on a miss |
| resp_hit | output | 1 | 1 on a hit, 0 on a miss |
| resp_first | output | 1 | 1 when the predicted way hit on the first try |

## Verification
Two functions can fall in the same cycle: a fill writing a set, and a lookup that reads the same set and updates that set's prediction bit. The bench provokes this by driving a fill and a request on the same clock edge. In one case the fill replaces the very line the lookup hits, so the response must still carry the old word. In the other case the fill targets the opposite way, so the hit and the fill both write the prediction bit. A follow-up lookup to the fill's line then has to hit on the first try, and a lookup to the overwritten tag has to miss, which shows which write took effect.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SECOND = 1'b1
    } lk_state_t;

    typedef logic way_t;

    function automatic way_t flip_way(way_t w);
        return ~w;
    endfunction

    typedef struct packed {
        logic hit;
        logic first;
    } resp_flags_t;

endpackage

// File: rtl/wpc_way_store.sv
module wpc_way_store #(
    parameter int SET_W  = 4,
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32,
    localparam int SETS  = 1 << SET_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic                        wr_way,
    input  logic [SET_W-1:0]            wr_idx,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [SET_W-1:0]            rd_idx,
    output logic [1:0][TAG_W-1:0]       rd_tag,
    output logic [1:0]                  rd_vld,
    output logic [1:0][DATA_W-1:0]      rd_data
);

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [TAG_W-1:0]  tag_q  [SETS];
        logic [DATA_W-1:0] data_q [SETS];
        logic [SETS-1:0]   vld_q;
        logic              wr_here;

        assign wr_here = wr_en && (wr_way == w[0]);

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
            end else if (wr_here) begin
                vld_q[wr_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_here) begin
                tag_q[wr_idx]  <= wr_tag;
                data_q[wr_idx] <= wr_data;
            end
        end

        assign rd_tag[w]  = tag_q[rd_idx];
        assign rd_data[w] = data_q[rd_idx];
        assign rd_vld[w]  = vld_q[rd_idx];
    end

endmodule

// File: rtl/wpc_predictor.sv
module wpc_predictor
    import wpc_pkg::*;
#(
    parameter int SET_W = 4,
    localparam int SETS = 1 << SET_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_idx,
    output way_t             rd_way,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_idx,
    input  way_t             upd_way,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_idx,
    input  way_t             fill_way
);

    logic [SETS-1:0] pred_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_q <= '0;
        end else begin
            if (upd_en) begin
                pred_q[upd_idx] <= upd_way;
            end
            // a fill is written last so it wins on a shared set
            if (fill_en) begin
                pred_q[fill_idx] <= fill_way;
            end
        end
    end

    assign rd_way = pred_q[rd_idx];

    AST_FILL_POINTS: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> pred_q[$past(fill_idx)] == $past(fill_way)); // R7

    AST_HIT_POINTS: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !(fill_en && fill_idx == upd_idx))
        |=> pred_q[$past(upd_idx)] == $past(upd_way)); // R6

endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SET_W  = 4,
    parameter int DATA_W = 32,
    localparam int TAG_W = ADDR_W - SET_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    output logic                   req_ready,
    output logic [SET_W-1:0]       lk_idx,
    input  logic [1:0][TAG_W-1:0]  way_tag,
    input  logic [1:0]             way_vld,
    input  logic [1:0][DATA_W-1:0] way_data,
    input  way_t                   pred_way,
    output logic                   upd_en,
    output way_t                   upd_way,
    output logic                   resp_valid,
    output logic [DATA_W-1:0]      resp_data,
    output logic                   resp_hit,
    output logic                   resp_first
);

    lk_state_t         st_q;
    logic [ADDR_W-1:0] hold_addr_q;
    way_t              hold_way_q;
    resp_flags_t       flags_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [TAG_W-1:0]  cur_tag;
    way_t              check_way;
    logic [DATA_W-1:0] spec_data;
    logic              tag_match;
    logic              accept;
    logic              active;

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign active    = accept || (st_q == ST_SECOND);

    assign cur_addr  = (st_q == ST_SECOND) ? hold_addr_q : req_addr;
    assign lk_idx    = cur_addr[SET_W-1:0];
    assign cur_tag   = cur_addr[ADDR_W-1:SET_W];

    // first try follows the prediction, second try the opposite way
    assign check_way = (st_q == ST_SECOND) ? flip_way(hold_way_q) : pred_way;

    // data mux steered before the compare result exists
    assign spec_data = way_data[check_way];
    assign tag_match = way_vld[check_way] && (way_tag[check_way] == cur_tag);

    assign upd_en  = active && tag_match;
    assign upd_way = check_way;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            resp_valid  <= 1'b0;
            resp_data   <= '0;
            flags_q     <= '0;
            hold_addr_q <= '0;
            hold_way_q  <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (tag_match) begin
                            resp_valid <= 1'b1;
                            resp_data  <= spec_data;
                            flags_q    <= '{hit: 1'b1, first: 1'b1};
                        end else begin
                            st_q        <= ST_SECOND;
                            hold_addr_q <= req_addr;
                            hold_way_q  <= pred_way;
                        end
                    end
                end
                ST_SECOND: begin
                    resp_valid <= 1'b1;
                    resp_data  <= tag_match ? spec_data : '0;
                    flags_q    <= '{hit: tag_match, first: 1'b0};
                    st_q       <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign resp_hit   = flags_q.hit;
    assign resp_first = flags_q.first;

    AST_FAST_HIT: assert property (@(posedge clk) disable iff (rst)
        (accept && tag_match) |=> (resp_valid && resp_first && resp_hit)); // R2

    AST_BUSY_AFTER_MISPRED: assert property (@(posedge clk) disable iff (rst)
        (accept && !tag_match) |=> !req_ready); // R5

    AST_SECOND_TRY_LATE: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> (resp_valid && !resp_first)); // R3

    AST_MISS_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> $past(!req_ready)); // R4

endmodule

// File: rtl/wp_cache_lookup.sv
module wp_cache_lookup
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SET_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_way,
    input  logic [DATA_W-1:0] fill_data,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              resp_hit,
    output logic              resp_first
);

    localparam int TAG_W = ADDR_W - SET_W;

    logic [SET_W-1:0]       lk_idx;
    logic [1:0][TAG_W-1:0]  way_tag;
    logic [1:0]             way_vld;
    logic [1:0][DATA_W-1:0] way_data;
    way_t                   pred_way;
    logic                   upd_en;
    way_t                   upd_way;

    wpc_way_store #(
        .SET_W (SET_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (fill_valid),
        .wr_way (fill_way),
        .wr_idx (fill_addr[SET_W-1:0]),
        .wr_tag (fill_addr[ADDR_W-1:SET_W]),
        .wr_data(fill_data),
        .rd_idx (lk_idx),
        .rd_tag (way_tag),
        .rd_vld (way_vld),
        .rd_data(way_data)
    );

    wpc_predictor #(
        .SET_W(SET_W)
    ) u_pred (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (lk_idx),
        .rd_way  (pred_way),
        .upd_en  (upd_en),
        .upd_idx (lk_idx),
        .upd_way (upd_way),
        .fill_en (fill_valid),
        .fill_idx(fill_addr[SET_W-1:0]),
        .fill_way(fill_way)
    );

    wpc_ctrl #(
        .ADDR_W(ADDR_W),
        .SET_W (SET_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .lk_idx    (lk_idx),
        .way_tag   (way_tag),
        .way_vld   (way_vld),
        .way_data  (way_data),
        .pred_way  (pred_way),
        .upd_en    (upd_en),
        .upd_way   (upd_way),
        .resp_valid(resp_valid),
        .resp_data (resp_data),
        .resp_hit  (resp_hit),
        .resp_first(resp_first)
    );

    AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ($past(req_valid && req_ready) || $past(!req_ready))); // R1

endmodule

// File: tb/sim_wp_cache_lookup.sv
module sim_wp_cache_lookup;

    localparam int ADDR_W = 16;
    localparam int SET_W  = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic              req_ready;
    logic              fill_valid;
    logic [ADDR_W-1:0] fill_addr;
    logic              fill_way;
    logic [DATA_W-1:0] fill_data;
    logic              resp_valid;
    logic [DATA_W-1:0] resp_data;
    logic              resp_hit;
    logic              resp_first;

    always #5 clk = ~clk;

    wp_cache_lookup #(
        .ADDR_W(ADDR_W),
        .SET_W (SET_W),
        .DATA_W(DATA_W)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .fill_valid(fill_valid),
        .fill_addr (fill_addr),
        .fill_way  (fill_way),
        .fill_data (fill_data),
        .resp_valid(resp_valid),
        .resp_data (resp_data),
        .resp_hit  (resp_hit),
        .resp_first(resp_first)
    );

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic              hit;
        logic              first;
        logic [DATA_W-1:0] data;
        int                at;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic push_exp(input logic hit, input logic first,
                            input logic [DATA_W-1:0] data, input string rq);
        exp_t e;
        e.hit   = hit;
        e.first = first;
        e.data  = data;
        e.at    = cyc + ((hit && first) ? 1 : 2);
        sb_q.push_back(e);
        tag_q.push_back(rq);
    endtask

    task automatic issue(input logic [ADDR_W-1:0] a, input logic hit,
                         input logic first, input logic [DATA_W-1:0] data,
                         input string rq);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        push_exp(hit, first, data, rq);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fill(input logic [ADDR_W-1:0] a, input logic w,
                        input logic [DATA_W-1:0] d);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = a;
        fill_way   = w;
        fill_data  = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic fill_with_req(input logic [ADDR_W-1:0] fa, input logic w,
                                 input logic [DATA_W-1:0] d,
                                 input logic [ADDR_W-1:0] ra, input logic hit,
                                 input logic first, input logic [DATA_W-1:0] data,
                                 input string rq);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = fa;
        fill_way   = w;
        fill_data  = d;
        req_valid  = 1'b1;
        req_addr   = ra;
        push_exp(hit, first, data, rq);
        @(negedge clk);
        fill_valid = 1'b0;
        req_valid  = 1'b0;
    endtask

    // monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R5", "unexpected response", 1, 0);
            end else begin
                exp_t  e;
                string rq;
                e  = sb_q.pop_front();
                rq = tag_q.pop_front();
                check(resp_hit == e.hit, rq, "hit", resp_hit, e.hit);
                check(resp_first == e.first, rq, "first", resp_first, e.first);
                check(resp_data == e.data, rq, "data", resp_data, e.data);
                check(cyc == e.at, rq, "cycle", cyc, e.at);
            end
        end
    end

    localparam logic [DATA_W-1:0] D_A1 = 32'hA1A1_0001;
    localparam logic [DATA_W-1:0] D_B2 = 32'hB2B2_0002;
    localparam logic [DATA_W-1:0] D_C7 = 32'hC7C7_0007;
    localparam logic [DATA_W-1:0] D_D4 = 32'hD4D4_0004;
    localparam logic [DATA_W-1:0] D_E6 = 32'hE6E6_0006;

    initial begin
        rst        = 1'b1;
        req_valid  = 1'b0;
        req_addr   = '0;
        fill_valid = 1'b0;
        fill_addr  = '0;
        fill_way   = 1'b0;
        fill_data  = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check(resp_valid == 1'b0, "R1", "resp_valid after reset", resp_valid, 0);

        issue(16'h0013, 1'b0, 1'b0, '0, "R1");           // cold miss
        fill(16'h0013, 1'b0, D_A1);
        issue(16'h0013, 1'b1, 1'b1, D_A1, "R2");         // predicted way 0 hits
        fill(16'h0023, 1'b1, D_B2);                      // R7: predictor -> way 1
        issue(16'h0023, 1'b1, 1'b1, D_B2, "R7");
        issue(16'h0013, 1'b1, 1'b0, D_A1, "R3");         // mispredict, way 0 hits
        issue(16'h0013, 1'b1, 1'b1, D_A1, "R6");         // now predicted
        issue(16'h0023, 1'b1, 1'b0, D_B2, "R3");         // mispredict, way 1 hits

        // R5: request while second check runs must be ignored
        issue(16'h0013, 1'b1, 1'b0, D_A1, "R5");
        req_valid = 1'b1;
        req_addr  = 16'h0023;
        @(negedge clk);
        req_valid = 1'b0;
        issue(16'h0013, 1'b1, 1'b1, D_A1, "R5");         // stray left predictor alone

        issue(16'h0033, 1'b0, 1'b0, '0, "R4");           // miss with both valid
        issue(16'h0013, 1'b1, 1'b1, D_A1, "R4");         // predictor unchanged

        fill(16'h0075, 1'b1, D_C7);
        issue(16'h0075, 1'b1, 1'b1, D_C7, "R9");
        issue(16'h0013, 1'b1, 1'b1, D_A1, "R9");         // set 3 unaffected

        // R8: fill replaces the line being looked up in the same cycle
        fill_with_req(16'h0063, 1'b0, D_E6, 16'h0013, 1'b1, 1'b1, D_A1, "R8");
        issue(16'h0013, 1'b0, 1'b0, '0, "R7");           // overwritten line gone
        // R8: hit sets way 0, fill sets way 1 in the same cycle; fill wins
        fill_with_req(16'h0043, 1'b1, D_D4, 16'h0063, 1'b1, 1'b1, D_E6, "R8");
        issue(16'h0043, 1'b1, 1'b1, D_D4, "R8");
        issue(16'h0023, 1'b0, 1'b0, '0, "R7");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R2", "responses outstanding", sb_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule